// File: doc/BRIEF.md
# Memory-Mapped Peripheral Register Block

This block is a bus slave placed next to the data-memory port of a small processor. It claims a 256-byte window of the address space and turns word loads and stores in that window into accesses to board peripherals. It keeps a 16-bit register that drives the LEDs and a 16-bit value for an external four-digit hex display driver. It samples 16 slide switches and 5 push buttons, and it runs a millisecond counter that software can read and reload.

The processor side is a plain address, write-data, write-strobe and read-strobe bus. Read data comes back registered, one clock after the read strobe, and is zero whenever no read was issued. Every register is 32 bits wide on the bus. Narrow fields are zero-extended on reads, and their upper bits are dropped on writes. A write changes a register only if the address is exactly that register's word address. Any other address, inside or outside the window, changes nothing. The raw switch and button pins pass through a two-stage synchronizer before software can see them.

Top module: `mmio_periph_regs`

## Requirements
- R1: Only addresses whose bits 31..8 equal 0x0000_7F form the window. A write outside the window changes no register, and a read outside the window returns 0.
- R2: A write to window offset 0x00 loads bits 15..0 of the write data into the LED register, which drives `led_out` (bit n drives LED n, 1 means on). Bits 31..16 of the write data are dropped.
- R3: A read at offset 0x00 returns the LED register in bits 15..0, with bits 31..16 zero.
- R4: A read at offset 0x04 returns the switches, with bit n taken from `sw_pins[n]` (bit 0 is the right-most switch) and bits 31..16 zero. A write to offset 0x04 changes no register.
- R5: A write to offset 0x18 loads bits 15..0 into the display value on `seg_value`. A read at 0x18 returns that value zero-extended.
- R6: A read at offset 0x24 returns the buttons in bits 4..0 in the order center, left, down, right, up (bit 0 is center, bit 4 is up), with 1 meaning pressed and bits 31..5 zero. Writes to 0x24 change nothing.
- R7: A read at offset 0x30 returns the millisecond counter. The counter rises by one, modulo 2^32, after every TICKS_PER_MS clock cycles.
- R8: A write to offset 0x30 loads the counter with the 32-bit write data and restarts the sub-millisecond prescaler from zero.
- R9: Writes change a register only at its exact byte offset (0x00, 0x18 or 0x30). Every other offset in the window, including unaligned ones, has no effect. Reads at unmapped or unaligned offsets return 0.
- R10: Read data is registered. A read strobe at clock edge k produces the data on `bus_rdata` after edge k, and `bus_rdata` is 0 after any edge at which no read was issued.
- R11: A change on a switch or button pin shows in a read whose strobe is sampled at the third rising edge after the change, and not in a read sampled at the first or second.
- R12: While reset is active, and until the synchronously released internal reset is removed, the LED register, display value, counter and read data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Store data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_re` |
| sw_pins | input | 16 | Raw slide switch levels |
| btn_pins | input | 5 | Raw button levels: center, left, down, right, up from bit 0 |
| led_out | output | 16 | LED drive, 1 lights the LED |
| seg_value | output | 16 | Four hex digits for the display driver |

## Verification
On every cycle the assertions check that the LED and display registers change only after an exact-offset store and then take its low half-word. They also check that read data is zero after an idle cycle, that reads outside the window return zero, and that narrow registers read back with clear upper bits. Only the bench scenarios can show the millisecond counting rate, the restart of the prescaler on a timer load, the counter wrap, the latency of the switch and button synchronizer, and the bit order of the switches and buttons. The bench sweeps every byte offset of the window for both stores and loads.

// File: rtl/periph_pkg.sv
package periph_pkg;
  localparam logic [7:0] OFF_LED = 8'h00;
  localparam logic [7:0] OFF_SW  = 8'h04;
  localparam logic [7:0] OFF_SEG = 8'h18;
  localparam logic [7:0] OFF_BTN = 8'h24;
  localparam logic [7:0] OFF_TMR = 8'h30;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LED,
    SEL_SW,
    SEL_SEG,
    SEL_BTN,
    SEL_TMR
  } periph_sel_e;
endpackage

// File: rtl/periph_decode.sv
module periph_decode
  import periph_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'h0000_7F00
) (
  input  logic [ADDR_W-1:0] addr,
  output periph_sel_e       sel
);
  logic       in_window;
  logic [7:0] offset;

  assign in_window = (addr[ADDR_W-1:8] == BASE[ADDR_W-1:8]);
  assign offset    = addr[7:0];

  always_comb begin
    sel = SEL_NONE;
    if (in_window) begin
      case (offset)
        OFF_LED: sel = SEL_LED;
        OFF_SW:  sel = SEL_SW;
        OFF_SEG: sel = SEL_SEG;
        OFF_BTN: sel = SEL_BTN;
        OFF_TMR: sel = SEL_TMR;
        default: sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/periph_sync.sv
module periph_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      q_sync   <= '0;
    end else begin
      stage1_q <= d_async;
      q_sync   <= stage1_q;
    end
  end
endmodule

// File: rtl/periph_ms_timer.sv
module periph_ms_timer #(
  parameter int CNT_W        = 32,
  parameter int TICKS_PER_MS = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);
  localparam int PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MS - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_d;
  logic             pre_wrap;

  assign pre_wrap = (pre_q == PRE_LAST);

  always_comb begin
    pre_d = pre_q;
    cnt_d = count;
    if (load) begin
      pre_d = '0;
      cnt_d = load_val;
    end else if (pre_wrap) begin
      pre_d = '0;
      cnt_d = count + CNT_W'(1);
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      count <= '0;
    end else begin
      pre_q <= pre_d;
      count <= cnt_d;
    end
  end
endmodule

// File: rtl/mmio_periph_regs.sv
module mmio_periph_regs
  import periph_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int LED_W        = 16,
  parameter int SW_W         = 16,
  parameter int BTN_W        = 5,
  parameter int SEG_W        = 16,
  parameter int TICKS_PER_MS = 100000,
  parameter logic [ADDR_W-1:0] BASE = 32'h0000_7F00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SW_W-1:0]   sw_pins,
  input  logic [BTN_W-1:0]  btn_pins,
  output logic [LED_W-1:0]  led_out,
  output logic [SEG_W-1:0]  seg_value
);
  // Reset: asserted asynchronously, removed on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  periph_sel_e sel;
  periph_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  logic [SW_W-1:0]  sw_s;
  logic [BTN_W-1:0] btn_s;
  periph_sync #(.W(SW_W)) u_sw_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .d_async (sw_pins),
    .q_sync  (sw_s)
  );
  periph_sync #(.W(BTN_W)) u_btn_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .d_async (btn_pins),
    .q_sync  (btn_s)
  );

  logic              tmr_load;
  logic [DATA_W-1:0] tmr_count;
  assign tmr_load = bus_we && (sel == SEL_TMR);
  periph_ms_timer #(.CNT_W(DATA_W), .TICKS_PER_MS(TICKS_PER_MS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (bus_wdata),
    .count    (tmr_count)
  );

  // Writable registers: explicit enables, next-state separate
  logic             led_en, seg_en;
  logic [LED_W-1:0] led_d;
  logic [SEG_W-1:0] seg_d;

  always_comb begin
    led_en = bus_we && (sel == SEL_LED);
    seg_en = bus_we && (sel == SEL_SEG);
    led_d  = bus_wdata[LED_W-1:0];
    seg_d  = bus_wdata[SEG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      led_out   <= '0;
      seg_value <= '0;
    end else begin
      if (led_en) led_out   <= led_d;
      if (seg_en) seg_value <= seg_d;
    end
  end

  // Read-back multiplexer, registered
  logic [DATA_W-1:0] rdata_d;
  always_comb begin
    rdata_d = '0;
    if (bus_re) begin
      case (sel)
        SEL_LED: rdata_d = DATA_W'(led_out);
        SEL_SW:  rdata_d = DATA_W'(sw_s);
        SEL_SEG: rdata_d = DATA_W'(seg_value);
        SEL_BTN: rdata_d = DATA_W'(btn_s);
        SEL_TMR: rdata_d = tmr_count;
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) bus_rdata <= '0;
    else             bus_rdata <= rdata_d;
  end
endmodule

// File: rtl/periph_regs_chk.sv
module periph_regs_chk
  import periph_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LED_W  = 16,
  parameter int SEG_W  = 16,
  parameter logic [ADDR_W-1:0] BASE = 32'h0000_7F00
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [LED_W-1:0]  led_out,
  input logic [SEG_W-1:0]  seg_value
);
  localparam logic [ADDR_W-1:0] A_LED = BASE | ADDR_W'(OFF_LED);
  localparam logic [ADDR_W-1:0] A_SEG = BASE | ADDR_W'(OFF_SEG);
  localparam logic [ADDR_W-1:0] A_TMR = BASE | ADDR_W'(OFF_TMR);

  p_led_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_LED) |=> led_out == $past(bus_wdata[LED_W-1:0]));

  p_led_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we || bus_addr != A_LED) |=> $stable(led_out));

  p_seg_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SEG) |=> seg_value == $past(bus_wdata[SEG_W-1:0]));

  p_seg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we || bus_addr != A_SEG) |=> $stable(seg_value));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> bus_rdata == '0);

  p_outside_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr[ADDR_W-1:8] != BASE[ADDR_W-1:8]) |=> bus_rdata == '0);

  p_narrow_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr != A_TMR) |=> bus_rdata[DATA_W-1:LED_W] == '0);
endmodule

bind mmio_periph_regs periph_regs_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .LED_W  (LED_W),
  .SEG_W  (SEG_W),
  .BASE   (BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .led_out   (led_out),
  .seg_value (seg_value)
);

// File: tb/mmio_periph_regs_tb.sv
`timescale 1ns/1ps
module mmio_periph_regs_tb;
  localparam int TICKS = 5;
  localparam logic [31:0] WB = 32'h0000_7F00;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_we, bus_re;
  logic [15:0] sw_pins, led_out, seg_value;
  logic [4:0]  btn_pins;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mmio_periph_regs #(.TICKS_PER_MS(TICKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .sw_pins(sw_pins), .btn_pins(btn_pins),
    .led_out(led_out), .seg_value(seg_value)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] v);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    v = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] v, exp;

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 0; bus_re = 0;
    sw_pins = 16'hA5C3; btn_pins = 5'h13;
    idle(4);
    check("R12 led_out in reset", {16'h0, led_out}, 32'h0);
    check("R12 rdata in reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    idle(3);
    rd(WB | 32'h30, v); check("R12 timer after reset", v, 32'h0);
    rd(WB | 32'h00, v); check("R12 led after reset", v, 32'h0);
    rd(WB | 32'h18, v); check("R12 seg after reset", v, 32'h0);

    // R10: latency and idle zero
    wr(WB, 32'h0000_BEEF);
    bus_addr = WB; bus_re = 1'b1;
    #1 check("R10 no data before edge", bus_rdata, 32'h0);
    @(negedge clk); bus_re = 1'b0;
    check("R10 data one cycle later", bus_rdata, 32'h0000_BEEF);
    idle(1); check("R10 zero when idle", bus_rdata, 32'h0);

    // R2 R3: LED sweep with upper bits set
    for (int i = 0; i < 40; i++) begin
      logic [31:0] d;
      d = (i + 1) * 32'h9E37_79B1;
      wr(WB, d);
      check("R2 led_out pins", {16'h0, led_out}, {16'h0, d[15:0]});
      rd(WB, v);
      check("R3 led readback", v, {16'h0, d[15:0]});
    end

    // R5: display sweep
    for (int i = 0; i < 40; i++) begin
      logic [31:0] d;
      d = (i + 3) * 32'h85EB_CA6B;
      wr(WB | 32'h18, d);
      check("R5 seg pins", {16'h0, seg_value}, {16'h0, d[15:0]});
      rd(WB | 32'h18, v);
      check("R5 seg readback", v, {16'h0, d[15:0]});
    end

    // R4: switch sweep, walking ones and patterns
    for (int i = 0; i < 20; i++) begin
      logic [15:0] s;
      s = (i < 16) ? (16'h1 << i) : 16'((i * 16'h3B71) ^ 16'hFFFF);
      sw_pins = s;
      idle(2);
      rd(WB | 32'h04, v);
      check("R4 switches", v, {16'h0, s});
    end

    // R6: every button combination
    for (int b = 0; b < 32; b++) begin
      btn_pins = 5'(b);
      idle(2);
      rd(WB | 32'h24, v);
      check("R6 buttons", v, 32'(b));
    end

    // R11: synchronizer latency
    sw_pins = 16'h0F0F; btn_pins = 5'h00; idle(3);
    sw_pins = 16'hF0F0; btn_pins = 5'h04;
    rd(WB | 32'h04, v); check("R11 sw 1st edge old", v, 32'h0F0F);
    rd(WB | 32'h04, v); check("R11 sw 2nd edge old", v, 32'h0F0F);
    rd(WB | 32'h24, v); check("R11 btn 3rd edge new", v, 32'h04);
    rd(WB | 32'h04, v); check("R11 sw 4th edge new", v, 32'hF0F0);

    // R9: write sweep of whole window
    wr(WB, 32'h1234); wr(WB | 32'h18, 32'h5678);
    for (int o = 0; o < 256; o++) begin
      if (o != 8'h00 && o != 8'h18 && o != 8'h30) wr(WB | 32'(o), 32'hDEAD_BEEF);
    end
    check("R9 led kept", {16'h0, led_out}, 32'h1234);
    check("R9 seg kept", {16'h0, seg_value}, 32'h5678);
    rd(WB, v); check("R4 sw write no effect on led", v, 32'h1234);

    // R1: outside window
    wr(32'h0000_8F00, 32'hFFFF); wr(32'h0001_7F00, 32'hFFFF); wr(32'h0000_6F18, 32'hFFFF);
    check("R1 led unaffected", {16'h0, led_out}, 32'h1234);
    check("R1 seg unaffected", {16'h0, seg_value}, 32'h5678);
    rd(32'h0001_7F00, v); check("R1 outside read zero", v, 32'h0);
    rd(32'h0000_7E04, v); check("R1 below window read zero", v, 32'h0);

    // R9: read sweep of whole window
    sw_pins = 16'hA5C3; btn_pins = 5'h13; idle(3);
    for (int o = 0; o < 256; o++) begin
      if (o != 8'h30) begin
        case (o)
          8'h00:   exp = 32'h1234;
          8'h04:   exp = 32'hA5C3;
          8'h18:   exp = 32'h5678;
          8'h24:   exp = 32'h13;
          default: exp = 32'h0;
        endcase
        rd(WB | 32'(o), v);
        check("R9 read sweep", v, exp);
      end
    end

    // R7 R8: counting and loading
    for (int d = 0; d < 24; d++) begin
      wr(WB | 32'h30, 32'd100);
      idle(d);
      rd(WB | 32'h30, v);
      check("R7 ms count", v, 32'd100 + 32'(d / TICKS));
    end
    idle(3);
    wr(WB | 32'h30, 32'd7);
    idle(TICKS - 1);
    rd(WB | 32'h30, v); check("R8 prescaler restarted", v, 32'd7);
    wr(WB | 32'h30, 32'hFFFF_FFFF);
    idle(TICKS);
    rd(WB | 32'h30, v); check("R7 counter wraps", v, 32'h0);
    wr(WB | 32'h30, 32'h0);
    idle(3 * TICKS);
    rd(WB | 32'h30, v); check("R8 clear then count", v, 32'd3);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule